// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block remembers where taken branches went, so the fetch unit can steer to the destination of a branch before the branch has been decoded. Every cycle the fetch unit presents its current fetch address. The block ignores the two lowest address bits and compares the rest against its stored line tags. On a match it returns the stored destination, and fetch uses that destination in place of the next sequential line. A correctly predicted taken branch therefore costs no bubble.

Entries are keyed by the quad-aligned address of the fetch line that contains the branch, not by the address of the branch instruction itself. The branch unit reports each resolved branch on a separate port. The report carries the line address, the destination, whether the branch was taken, a per-instruction flag that forbids prediction, and whether fetch had redirected on it.

A taken branch without an entry claims one. The block fills an empty way of the set first and otherwise evicts the least recently used way. A redirected branch that falls through raises a mispredict, so the pipeline can discard the wrong path and restart sequential fetch. A flush empties the whole buffer in one cycle.

Top module: `fetch_btb`

## Requirements
- R1: While reset is asserted, and in every cycle after reset until the first allocation, `lk_hit_o` is 0 and `lk_target_o` is 0.
- R2: Address bits [6:2] select one of 32 sets and bits [31:7] form the tag. Bits [1:0] are ignored. A lookup whose set and tag match a valid entry gives `lk_hit_o`=1 and `lk_target_o` equal to the stored destination in the same cycle.
- R3: A lookup that matches no valid entry gives `lk_hit_o`=0 and `lk_target_o`=0. At most one way of a set ever matches.
- R4: A resolve with valid=1, taken=1 and nopred=0 whose line has no entry writes a new entry at the clock edge. From the next cycle a lookup of that line hits with the reported destination.
- R5: A resolve with nopred=1 never creates an entry and never changes the destination of an existing entry.
- R6: A resolve with taken=0 creates no entry.
- R7: A taken, predictable resolve whose line already has an entry overwrites that entry's destination. It does not use a second way and does not change recency.
- R8: An allocation goes into the lowest-numbered invalid way of the set when one exists.
- R9: When all four ways of a set are valid, an allocation evicts the least recently used way. Recency is refreshed by every lookup hit and every allocation. After reset the recency order is way 0 (most recent) through way 3 (least recent).
- R10: `rs_mispredict_o` is 1, in the same cycle, exactly when valid=1, predicted=1 and taken=0. A mispredict leaves the buffer contents unchanged.
- R11: A flush clears every valid bit in one cycle. It overrides an allocation or overwrite in the same cycle and leaves recency untouched. A lookup in the flush cycle still sees the contents held before the flush.
- R12: When a lookup hits and an allocation lands in the same set in the same cycle, the lookup returns the contents held before the edge. The recency update applies the allocated way first and then the hit way, so the hit way ends most recent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_addr_i | input | ADDR_W | Current fetch address |
| lk_hit_o | output | 1 | Lookup matched a valid entry |
| lk_target_o | output | ADDR_W | Predicted next fetch address (0 on miss) |
| rs_valid_i | input | 1 | A branch resolution is reported this cycle |
| rs_line_i | input | ADDR_W | Address of the fetch line holding the branch |
| rs_target_i | input | ADDR_W | Resolved branch destination |
| rs_taken_i | input | 1 | Branch was taken |
| rs_nopred_i | input | 1 | Branch is marked never-predict |
| rs_predicted_i | input | 1 | Fetch had redirected on this branch |
| rs_mispredict_o | output | 1 | Redirect was wrong; flush and refetch |

## Verification
The lookup port and the resolve port act independently. In one cycle a lookup can hit in the same set that an allocation is writing, and the victim may even be the very way being hit. The bench provokes this by holding a lookup on a resident line while it reports a new taken branch for the same set. It expects the old destination on the output, and later it checks which line was evicted by looking up all the set's members. The flush-plus-allocation collision is provoked the same way. Every outcome is judged against a behavioural model that applies the updates in the stated order.

// File: rtl/btb_pkg.sv
package btb_pkg;

   // Kind of array write requested by a branch resolution
   typedef enum logic [1:0] {
      UPD_NONE     = 2'd0,
      UPD_ALLOC    = 2'd1,
      UPD_RETARGET = 2'd2
   } btb_upd_e;

endpackage

// File: rtl/btb_match.sv
module btb_match #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned TAG_W = 25,
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
   input  logic [WAYS-1:0]            vld_i,
   input  logic [TAG_W-1:0]           tag_i,
   output logic [WAYS-1:0]            match_o,
   output logic                       hit_o,
   output logic [WAY_W-1:0]           way_o
);

   always_comb begin
      hit_o = 1'b0;
      way_o = '0;
      for (int w = 0; w < WAYS; w++) begin
         match_o[w] = vld_i[w] && (tags_i[w] == tag_i);
         if (match_o[w] && !hit_o) begin
            hit_o = 1'b1;
            way_o = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
   parameter int unsigned WAYS = 4,
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  vld_i,
   input  logic [WAY_W-1:0] lru_i,
   output logic [WAY_W-1:0] victim_o
);

   always_comb begin
      logic found;
      found    = 1'b0;
      victim_o = lru_i;
      for (int w = 0; w < WAYS; w++) begin
         if (!vld_i[w] && !found) begin
            found    = 1'b1;
            victim_o = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
   parameter int unsigned WAYS = 4,
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_en_i,
   input  logic [WAY_W-1:0] a_way_i,
   input  logic             b_en_i,
   input  logic [WAY_W-1:0] b_way_i,
   output logic [WAY_W-1:0] lru_way_o
);

   typedef logic [WAYS-1:0][WAY_W-1:0] ord_t;

   // slot 0 holds the most recent way, slot WAYS-1 the least recent
   ord_t ord_q, ord_a, ord_b;

   function automatic ord_t promote(ord_t o, logic [WAY_W-1:0] w);
      ord_t n;
      int   p;
      p = WAYS - 1;
      for (int i = WAYS - 1; i >= 0; i--)
         if (o[i] == w) p = i;
      n[0] = w;
      for (int i = 1; i < WAYS; i++)
         n[i] = (i <= p) ? o[i-1] : o[i];
      return n;
   endfunction

   always_comb begin
      ord_a = a_en_i ? promote(ord_q, a_way_i) : ord_q;
      ord_b = b_en_i ? promote(ord_a, b_way_i) : ord_a;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WAYS; i++) ord_q[i] <= WAY_W'(i);
      end else begin
         ord_q <= ord_b;
      end
   end

   assign lru_way_o = ord_q[WAYS-1];

   logic [WAYS-1:0] seen;
   always_comb begin
      seen = '0;
      for (int i = 0; i < WAYS; i++) seen[ord_q[i]] = 1'b1;
   end

   // recency list must always name every way exactly once
   assert_lru_perm_R9: assert property (@(posedge clk) disable iff (!rst_n) (&seen));

   // a promoted way becomes most recent at the next edge
   assert_lru_front_R12: assert property (@(posedge clk) disable iff (!rst_n)
      b_en_i |=> (ord_q[0] == $past(b_way_i)));

endmodule

// File: rtl/fetch_btb.sv
module fetch_btb
   import btb_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SETS   = 32,
   parameter int unsigned WAYS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic [ADDR_W-1:0] lk_addr_i,
   output logic              lk_hit_o,
   output logic [ADDR_W-1:0] lk_target_o,
   input  logic              rs_valid_i,
   input  logic [ADDR_W-1:0] rs_line_i,
   input  logic [ADDR_W-1:0] rs_target_i,
   input  logic              rs_taken_i,
   input  logic              rs_nopred_i,
   input  logic              rs_predicted_i,
   output logic              rs_mispredict_o
);

   localparam int unsigned IDX_W = $clog2(SETS);
   localparam int unsigned WAY_W = $clog2(WAYS);
   localparam int unsigned TAG_W = ADDR_W - IDX_W - 2;

   // elaboration-time parameter checks
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (ADDR_W <= IDX_W + 3) begin : g_bad_addr
      $error("ADDR_W too small for the set index");
   end

   // storage
   logic [SETS-1:0][WAYS-1:0] vld_q;
   logic [TAG_W-1:0]          tag_q [SETS][WAYS];
   logic [ADDR_W-1:0]         tgt_q [SETS][WAYS];
   logic [SETS-1:0][WAY_W-1:0] lru_way;

   // address split (bits [1:0] select a word inside the quad and are ignored)
   logic [IDX_W-1:0] lk_idx, rs_idx;
   logic [TAG_W-1:0] lk_tag, rs_tag;
   assign lk_idx = lk_addr_i[IDX_W+1:2];
   assign lk_tag = lk_addr_i[ADDR_W-1:IDX_W+2];
   assign rs_idx = rs_line_i[IDX_W+1:2];
   assign rs_tag = rs_line_i[ADDR_W-1:IDX_W+2];

   // set rows for both ports
   logic [WAYS-1:0][TAG_W-1:0] lk_tags, rs_tags;
   logic [WAYS-1:0]            lk_vld, rs_vld;
   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         lk_tags[w] = tag_q[lk_idx][w];
         rs_tags[w] = tag_q[rs_idx][w];
      end
      lk_vld = vld_q[lk_idx];
      rs_vld = vld_q[rs_idx];
   end

   // lookup port
   logic [WAYS-1:0]  lk_match;
   logic             lk_hit;
   logic [WAY_W-1:0] lk_way;
   btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
      .tags_i (lk_tags),
      .vld_i  (lk_vld),
      .tag_i  (lk_tag),
      .match_o(lk_match),
      .hit_o  (lk_hit),
      .way_o  (lk_way)
   );

   assign lk_hit_o    = lk_hit;
   assign lk_target_o = lk_hit ? tgt_q[lk_idx][lk_way] : '0;

   // resolve port
   logic [WAYS-1:0]  rs_match;
   logic             rs_hit;
   logic [WAY_W-1:0] rs_way;
   btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_rs_match (
      .tags_i (rs_tags),
      .vld_i  (rs_vld),
      .tag_i  (rs_tag),
      .match_o(rs_match),
      .hit_o  (rs_hit),
      .way_o  (rs_way)
   );

   logic [WAY_W-1:0] victim;
   btb_victim #(.WAYS(WAYS)) u_victim (
      .vld_i   (rs_vld),
      .lru_i   (lru_way[rs_idx]),
      .victim_o(victim)
   );

   btb_upd_e         upd;
   logic [WAY_W-1:0] wr_way;
   always_comb begin
      upd = UPD_NONE;
      if (rs_valid_i && rs_taken_i && !rs_nopred_i && !flush_i)
         upd = rs_hit ? UPD_RETARGET : UPD_ALLOC;
      wr_way = rs_hit ? rs_way : victim;
   end

   assign rs_mispredict_o = rs_valid_i && rs_predicted_i && !rs_taken_i;

   // recency, one list per set
   for (genvar s = 0; s < SETS; s++) begin : g_set
      btb_lru #(.WAYS(WAYS)) u_lru (
         .clk      (clk),
         .rst_n    (rst_n),
         .a_en_i   ((upd == UPD_ALLOC) && (rs_idx == IDX_W'(s))),
         .a_way_i  (victim),
         .b_en_i   (lk_hit && !flush_i && (lk_idx == IDX_W'(s))),
         .b_way_i  (lk_way),
         .lru_way_o(lru_way[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (flush_i) begin
         vld_q <= '0;
      end else if (upd == UPD_ALLOC) begin
         vld_q[rs_idx][victim] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (upd != UPD_NONE) begin
         tag_q[rs_idx][wr_way] <= rs_tag;
         tgt_q[rs_idx][wr_way] <= rs_target_i;
      end
   end

   // checks next to the logic
   logic [$clog2(SETS*WAYS+1)-1:0] vcount;
   assign vcount = $countones(vld_q);

   assert_one_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   assert_alloc_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd == UPD_ALLOC) |=> (({lk_tag, lk_idx} != $past({rs_tag, rs_idx})) ||
                              (lk_hit_o && lk_target_o == $past(rs_target_i))));

   assert_nopred_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid_i && rs_nopred_i) |=> (vcount <= $past(vcount)));

   assert_victim_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((upd == UPD_ALLOC) && !(&rs_vld)) |-> !rs_vld[victim]);

   assert_mispredict_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_mispredict_o && !flush_i) |=> $stable(vld_q));

   assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (vld_q == '0 && !lk_hit_o));

endmodule

// File: tb/fetch_btb_test.sv
`timescale 1ns/1ps
module fetch_btb_test;

   localparam int SETS = 32;
   localparam int WAYS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic [31:0] lk_addr_i = '0;
   logic        lk_hit_o;
   logic [31:0] lk_target_o;
   logic        rs_valid_i = 1'b0;
   logic [31:0] rs_line_i = '0;
   logic [31:0] rs_target_i = '0;
   logic        rs_taken_i = 1'b0;
   logic        rs_nopred_i = 1'b0;
   logic        rs_predicted_i = 1'b0;
   logic        rs_mispredict_o;

   always #2.5 clk = ~clk;

   fetch_btb uut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .lk_addr_i(lk_addr_i), .lk_hit_o(lk_hit_o), .lk_target_o(lk_target_o),
      .rs_valid_i(rs_valid_i), .rs_line_i(rs_line_i), .rs_target_i(rs_target_i),
      .rs_taken_i(rs_taken_i), .rs_nopred_i(rs_nopred_i),
      .rs_predicted_i(rs_predicted_i), .rs_mispredict_o(rs_mispredict_o)
   );

   // behavioural reference
   bit          mv [SETS][WAYS];
   logic [24:0] mt [SETS][WAYS];
   logic [31:0] mg [SETS][WAYS];
   int          rq [SETS][$];

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   string cur_req = "R1";

   function automatic logic [31:0] mk(int tag, int idx, int off);
      return {tag[24:0], idx[4:0], off[1:0]};
   endfunction

   function automatic int find(int idx, logic [24:0] tag);
      for (int w = 0; w < WAYS; w++)
         if (mv[idx][w] && mt[idx][w] == tag) return w;
      return -1;
   endfunction

   function automatic void touch(int idx, int w);
      for (int i = 0; i < rq[idx].size(); i++)
         if (rq[idx][i] == w) begin rq[idx].delete(i); break; end
      rq[idx].push_front(w);
   endfunction

   function automatic void model_reset();
      for (int s = 0; s < SETS; s++) begin
         rq[s].delete();
         for (int w = 0; w < WAYS; w++) begin
            mv[s][w] = 0;
            rq[s].push_back(w);
         end
      end
   endfunction

   task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   // one cycle: compare combinational outputs, then advance the model at the edge
   task automatic cyc();
      int          h, li, ri, rh, vic;
      logic [24:0] lt, rt;
      bit          ehit, emp;
      logic [31:0] etgt;
      #1;
      li = int'(lk_addr_i[6:2]);
      lt = lk_addr_i[31:7];
      h  = rst_n ? find(li, lt) : -1;
      ehit = (h >= 0);
      etgt = ehit ? mg[li][h] : 32'h0;
      emp  = rs_valid_i && rs_predicted_i && !rs_taken_i;
      check(lk_hit_o == ehit, "lookup hit", 32'(lk_hit_o), 32'(ehit));
      check(lk_target_o == etgt, "lookup target", lk_target_o, etgt);
      check(rs_mispredict_o == emp, "mispredict", 32'(rs_mispredict_o), 32'(emp));
      @(posedge clk);
      if (!rst_n) begin
         model_reset();
      end else if (flush_i) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) mv[s][w] = 0;
      end else begin
         ri = int'(rs_line_i[6:2]);
         rt = rs_line_i[31:7];
         rh = find(ri, rt);
         if (rs_valid_i && rs_taken_i && !rs_nopred_i) begin
            if (rh >= 0) begin
               mg[ri][rh] = rs_target_i;
            end else begin
               vic = -1;
               for (int w = 0; w < WAYS; w++)
                  if (!mv[ri][w] && vic < 0) vic = w;
               if (vic < 0) vic = rq[ri][$];
               mv[ri][vic] = 1;
               mt[ri][vic] = rt;
               mg[ri][vic] = rs_target_i;
               touch(ri, vic);
            end
         end
         if (h >= 0) touch(li, h);
      end
      @(negedge clk);
   endtask

   task automatic rs(bit v, logic [31:0] line, logic [31:0] tgt, bit tk, bit np, bit pr);
      rs_valid_i = v; rs_line_i = line; rs_target_i = tgt;
      rs_taken_i = tk; rs_nopred_i = np; rs_predicted_i = pr;
   endtask

   task automatic idle_rs();
      rs(0, 32'h0, 32'h0, 0, 0, 0);
   endtask

   task automatic look(logic [31:0] a);
      lk_addr_i = a;
      cyc();
   endtask

   initial begin
      model_reset();
      @(negedge clk);
      // R1: reset state
      cur_req = "R1";
      lk_addr_i = mk(1, 3, 0);
      repeat (3) cyc();
      rst_n = 1'b1;
      look(mk(1, 3, 0));
      look(mk(7, 0, 2));

      // R4 and R2: allocate, then hit from any word of the quad
      cur_req = "R4";
      rs(1, mk(1, 3, 2), 32'h0000_1000, 1, 0, 0);
      look(mk(1, 3, 0));
      idle_rs();
      look(mk(1, 3, 0));
      cur_req = "R2";
      look(mk(1, 3, 3));
      look(mk(1, 3, 1));

      // R3: same set other tag, same tag other set
      cur_req = "R3";
      look(mk(2, 3, 0));
      look(mk(1, 4, 0));

      // R5: never-predict branches neither allocate nor retarget
      cur_req = "R5";
      rs(1, mk(5, 9, 0), 32'h0000_5000, 1, 1, 0);
      look(mk(5, 9, 0));
      idle_rs();
      look(mk(5, 9, 1));
      rs(1, mk(1, 3, 0), 32'h0000_dead, 1, 1, 0);
      look(mk(0, 0, 0));
      idle_rs();
      look(mk(1, 3, 0));

      // R6: not-taken branch does not allocate
      cur_req = "R6";
      rs(1, mk(6, 9, 0), 32'h0000_6000, 0, 0, 0);
      look(mk(0, 0, 0));
      idle_rs();
      look(mk(6, 9, 0));

      // R7: taken again on a resident line rewrites the destination
      cur_req = "R7";
      rs(1, mk(1, 3, 1), 32'h0000_2000, 1, 0, 1);
      look(mk(0, 0, 0));
      idle_rs();
      look(mk(1, 3, 2));

      // R8: fill set 12 through its empty ways
      cur_req = "R8";
      for (int t = 10; t < 14; t++) begin
         rs(1, mk(t, 12, 0), 32'h100 * t, 1, 0, 0);
         look(mk(0, 0, 0));
      end
      idle_rs();
      for (int t = 10; t < 14; t++) look(mk(t, 12, 0));

      // R9: full set evicts least recent; refresh tag 10 first
      cur_req = "R9";
      look(mk(10, 12, 0));
      rs(1, mk(14, 12, 0), 32'h0000_e000, 1, 0, 0);
      look(mk(0, 0, 0));
      idle_rs();
      for (int t = 10; t < 15; t++) look(mk(t, 12, 0));

      // R10: mispredict reported, entry kept
      cur_req = "R10";
      rs(1, mk(10, 12, 0), 32'h0, 0, 0, 1);
      look(mk(10, 12, 0));
      rs(1, mk(10, 12, 0), 32'h0, 0, 0, 0);
      look(mk(10, 12, 0));
      idle_rs();
      look(mk(10, 12, 0));

      // R12: lookup hit and allocation in one set in one cycle
      cur_req = "R12";
      rs(1, mk(20, 12, 0), 32'h0002_0000, 1, 0, 0);
      look(mk(12, 12, 0));
      rs(1, mk(21, 12, 0), 32'h0002_1000, 1, 0, 0);
      look(mk(13, 12, 0));
      idle_rs();
      for (int t = 10; t < 22; t++) look(mk(t, 12, 0));

      // R11: flush beats a same-cycle allocation
      cur_req = "R11";
      flush_i = 1'b1;
      rs(1, mk(30, 20, 0), 32'h0003_0000, 1, 0, 0);
      look(mk(1, 3, 0));
      flush_i = 1'b0;
      idle_rs();
      look(mk(30, 20, 0));
      look(mk(1, 3, 0));
      look(mk(20, 12, 0));

      // R9: mixed traffic over few sets and tags
      cur_req = "R9";
      for (int n = 0; n < 3000; n++) begin
         flush_i = ($urandom_range(0, 59) == 0);
         rs($urandom_range(0, 1), mk($urandom_range(0, 5), $urandom_range(0, 2), $urandom_range(0, 3)),
            $urandom, $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0, $urandom_range(0, 1));
         look(mk($urandom_range(0, 5), $urandom_range(0, 2), $urandom_range(0, 3)));
      end
      flush_i = 1'b0;
      idle_rs();
      look(mk(0, 0, 0));

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'h0, 32'h1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule